// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts cycles and hardware events so that software can locate the dominant bottleneck of a workload. It holds one 64-bit cycle counter and a parameterised bank of 32-bit event counters, six by default. Each event counter is tied to one event code. Events arrive as one-cycle pulses on an input vector indexed by code. Two codes are handled inside the block: one counts every clock, and the other counts increments requested by software.

Software reaches the unit over a simple word-addressed register bus. Counter enables and interrupt enables are each held in a pair of set/clear registers. Event counters and their type registers are reached indirectly, through a counter-select register. The cycle counter can flag overflow at either 32 or 64 bits. A sticky overflow status drives a level interrupt. A privilege input gates reads made by unprivileged software, and a user-access register can relax that gate.

Top module: `perf_mon_unit`

## Requirements
- R1: Word address 0 is control. Bit 0 is the global enable and bit 6 is the long-cycle select; both read back as written. Bits [15:11] always read the number of event counters N. Bits 1 and 2 read 0.
- R2: Enable-set (address 1) ORs in the written ones and enable-clear (address 2) removes them. Zeros have no effect. Both addresses read the mask, in which bits 0..N-1 belong to the event counters and bit 31 to the cycle counter. Every other bit reads 0.
- R3: A counter advances only in a cycle where both the global enable and its own enable bit are 1. An event counter of type c (1..EVT_W-1, c ≠ 0x0011) adds one for each clock in which events[c] is high.
- R4: An event counter of type 0x0011 adds one on every enabled clock, exactly as the cycle counter does.
- R5: Writing to the software-increment register (address 12) advances counter n by one for each written bit n, provided counter n has type 0x0000 and is enabled. Other counters are unaffected.
- R6: Writing control with bit 2 set zeroes every event counter. Writing it with bit 1 set zeroes the cycle counter.
- R7: The select register (address 6, bits [4:0]) picks counter n. The type register (address 7, low 16 bits) and the count register (address 8) then act on counter n. When n ≥ N, writes to these two addresses are ignored and reads return 0.
- R8: When an event counter n wraps from 0xFFFFFFFF to 0, bit n of the overflow status (address 5) is set. The bit stays set until a 1 is written to it.
- R9: The cycle counter is 64 bits wide, with its low half at address 9 and its high half at address 10. When control bit 6 is 0, a wrap of the low 32 bits sets status bit 31. When bit 6 is 1, only a wrap of all 64 bits sets it.
- R10: The interrupt-enable mask (set at address 3, clear at address 4, same bit layout as the enable mask) gates the status. irq is high exactly while some status bit and its interrupt-enable bit are both 1.
- R11: The user-access register is at address 11. When bus_priv is 0, a read is allowed only if user bit 0 is set, or if user bit 2 is set and the read targets address 9 or 10. A blocked read returns 0 and raises acc_err for one cycle. Privileged reads are never blocked.
- R12: Read data and acc_err are registered and appear in the cycle after the request. After reset every register and counter is 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| events | input | EVT_W | One-cycle event pulses, indexed by event code |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| acc_err | output | 1 | Pulse marking a blocked unprivileged read |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest states to reach from the ports are the counter wraps: 2^32 events cannot be driven in a test. The stimulus therefore loads event counters and the cycle-counter halves through the indirect write path to a few counts short of the limit, then supplies a handful of pulses or clocks. It does this once with the long-cycle select set and once with it clear, which splits 32-bit from 64-bit overflow. Cycle-exact counts depend on the one-cycle latency between a control write and the enable taking effect, so the expected totals are worked out from the number of clock edges between the enable write and the disable write. Random event vectors from a fixed seed are checked against a bench tally of the selected code's bit.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_EN_SET = 4'd1,
    RA_EN_CLR = 4'd2,
    RA_IE_SET = 4'd3,
    RA_IE_CLR = 4'd4,
    RA_OVF    = 4'd5,
    RA_SEL    = 4'd6,
    RA_TYPE   = 4'd7,
    RA_CNT    = 4'd8,
    RA_CYC_LO = 4'd9,
    RA_CYC_HI = 4'd10,
    RA_USER   = 4'd11,
    RA_SWINC  = 4'd12
  } pmu_reg_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_CCLR  = 1;
  localparam int CTL_ECLR  = 2;
  localparam int CTL_LONG  = 6;
  localparam int CTL_N_LSB = 11;
  localparam int CTL_N_W   = 5;

  localparam int CYC_SLOT  = 31;
  localparam int USR_ALL   = 0;
  localparam int USR_CYC   = 2;

  localparam logic [15:0] EV_SWINC  = 16'h0000;
  localparam logic [15:0] EV_CYCLES = 16'h0011;

endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int EVT_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [EVT_W-1:0] events,
  input  logic             sw_inc,
  input  logic             clr,
  input  logic             wr_type,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [15:0]      type_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  localparam int IDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic             hit;
  logic             inc;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_d;

  // event source selection by code
  always_comb begin
    hit = 1'b0;
    if (type_q == EV_SWINC) begin
      hit = sw_inc;
    end else if (type_q == EV_CYCLES) begin
      hit = 1'b1;
    end else if (type_q < 16'(EVT_W)) begin
      hit = events[type_q[IDX_W-1:0]];
    end
  end

  always_comb begin
    inc    = cnt_en & hit;
    cnt_ld = clr | wr_cnt | inc;
    if (clr) begin
      cnt_d = '0;
    end else if (wr_cnt) begin
      cnt_d = wdata;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    wrap = inc & ~clr & ~wr_cnt & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_type) type_q <= wdata[15:0];
      if (cnt_ld)  cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              long_mode,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] cnt_q,
  output logic              wrap
);

  logic              lo_ld, hi_ld;
  logic [2*HALF_W-1:0] inc_val;
  logic [HALF_W-1:0] lo_d, hi_d;
  logic              busy;

  always_comb begin
    inc_val = cnt_q + (2*HALF_W)'(1);
    busy    = clr | wr_lo | wr_hi;
    lo_ld   = busy | cnt_en;
    hi_ld   = busy | cnt_en;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else if (wr_lo | wr_hi) begin
      lo_d = wr_lo ? wdata : cnt_q[HALF_W-1:0];
      hi_d = wr_hi ? wdata : cnt_q[2*HALF_W-1:HALF_W];
    end else begin
      lo_d = inc_val[HALF_W-1:0];
      hi_d = inc_val[2*HALF_W-1:HALF_W];
    end
    wrap = cnt_en & ~busy &
           (long_mode ? (&cnt_q) : (&cnt_q[HALF_W-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      if (lo_ld) cnt_q[HALF_W-1:0]        <= lo_d;
      if (hi_ld) cnt_q[2*HALF_W-1:HALF_W] <= hi_d;
    end
  end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int EVT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] events,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_priv,
  output logic [31:0]      bus_rdata,
  output logic             acc_err,
  output logic             irq
);

  localparam int SEL_W = 5;
  localparam logic [31:0] EVT_MASK  = 32'((64'd1 << NUM_EVT) - 64'd1);
  localparam logic [31:0] IMPL_MASK = EVT_MASK | (32'd1 << CYC_SLOT);

  // architectural state
  logic             ctrl_en_q, ctrl_long_q;
  logic [31:0]      en_q, ie_q, ovf_q;
  logic [SEL_W-1:0] sel_q;
  logic [2:0]       usr_q;
  logic [31:0]      rdata_q;
  logic             err_q;

  // next-state
  logic             ctrl_ld, en_ld, ie_ld, ovf_ld, sel_ld, usr_ld;
  logic [31:0]      en_d, ie_d, ovf_d;
  logic [31:0]      rdata_d;
  logic             err_d;

  // decode
  logic wr, rd;
  logic clr_evt, clr_cyc, wr_type, wr_cnt, wr_swinc, wr_lo, wr_hi;
  logic rd_allowed;
  logic [31:0] rd_val;

  // counter bank
  logic [31:0]        evt_cnt  [NUM_EVT];
  logic [15:0]        evt_type [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap;
  logic [63:0]        cyc_cnt;
  logic               cyc_wrap;
  logic [31:0]        wrap_vec;
  logic [15:0]        sel_type;
  logic [31:0]        sel_cnt;

  always_comb begin
    wr       = bus_req & bus_we;
    rd       = bus_req & ~bus_we;
    clr_evt  = wr & (bus_addr == RA_CTRL) & bus_wdata[CTL_ECLR];
    clr_cyc  = wr & (bus_addr == RA_CTRL) & bus_wdata[CTL_CCLR];
    wr_type  = wr & (bus_addr == RA_TYPE);
    wr_cnt   = wr & (bus_addr == RA_CNT);
    wr_swinc = wr & (bus_addr == RA_SWINC);
    wr_lo    = wr & (bus_addr == RA_CYC_LO);
    wr_hi    = wr & (bus_addr == RA_CYC_HI);
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    pmu_evt_counter #(.EVT_W(EVT_W), .CNT_W(32)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (ctrl_en_q & en_q[i]),
      .events (events),
      .sw_inc (wr_swinc & bus_wdata[i]),
      .clr    (clr_evt),
      .wr_type(wr_type & (sel_q == SEL_W'(i))),
      .wr_cnt (wr_cnt & (sel_q == SEL_W'(i))),
      .wdata  (bus_wdata),
      .type_q (evt_type[i]),
      .cnt_q  (evt_cnt[i]),
      .wrap   (evt_wrap[i])
    );
  end

  pmu_cyc_counter #(.HALF_W(32)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (ctrl_en_q & en_q[CYC_SLOT]),
    .long_mode(ctrl_long_q),
    .clr      (clr_cyc),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (bus_wdata),
    .cnt_q    (cyc_cnt),
    .wrap     (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_SLOT]    = cyc_wrap;
  end

  // indirect read view; out-of-range select leaves zero
  always_comb begin
    sel_type = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_type = evt_type[i];
        sel_cnt  = evt_cnt[i];
      end
    end
  end

  // control-side next state
  always_comb begin
    ctrl_ld = wr & (bus_addr == RA_CTRL);
    sel_ld  = wr & (bus_addr == RA_SEL);
    usr_ld  = wr & (bus_addr == RA_USER);

    en_ld = wr & ((bus_addr == RA_EN_SET) | (bus_addr == RA_EN_CLR));
    en_d  = (bus_addr == RA_EN_SET) ? (en_q | (bus_wdata & IMPL_MASK))
                                    : (en_q & ~bus_wdata);
    ie_ld = wr & ((bus_addr == RA_IE_SET) | (bus_addr == RA_IE_CLR));
    ie_d  = (bus_addr == RA_IE_SET) ? (ie_q | (bus_wdata & IMPL_MASK))
                                    : (ie_q & ~bus_wdata);

    ovf_d = ovf_q;
    if (wr && bus_addr == RA_OVF) ovf_d = ovf_d & ~bus_wdata;
    ovf_d  = ovf_d | wrap_vec;
    ovf_ld = (|wrap_vec) | (wr & (bus_addr == RA_OVF));
  end

  // read path with access gating
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      RA_CTRL: begin
        rd_val[CTL_EN]   = ctrl_en_q;
        rd_val[CTL_LONG] = ctrl_long_q;
        rd_val[CTL_N_LSB +: CTL_N_W] = CTL_N_W'(NUM_EVT);
      end
      RA_EN_SET, RA_EN_CLR: rd_val = en_q;
      RA_IE_SET, RA_IE_CLR: rd_val = ie_q;
      RA_OVF:    rd_val = ovf_q;
      RA_SEL:    rd_val = 32'(sel_q);
      RA_TYPE:   rd_val = 32'(sel_type);
      RA_CNT:    rd_val = sel_cnt;
      RA_CYC_LO: rd_val = cyc_cnt[31:0];
      RA_CYC_HI: rd_val = cyc_cnt[63:32];
      RA_USER:   rd_val = 32'(usr_q);
      default:   rd_val = '0;
    endcase
    rd_allowed = bus_priv | usr_q[USR_ALL] |
                 (usr_q[USR_CYC] & ((bus_addr == RA_CYC_LO) | (bus_addr == RA_CYC_HI)));
    rdata_d = (rd && rd_allowed) ? rd_val : '0;
    err_d   = rd & ~rd_allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q   <= 1'b0;
      ctrl_long_q <= 1'b0;
      en_q        <= '0;
      ie_q        <= '0;
      ovf_q       <= '0;
      sel_q       <= '0;
      usr_q       <= '0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      if (ctrl_ld) begin
        ctrl_en_q   <= bus_wdata[CTL_EN];
        ctrl_long_q <= bus_wdata[CTL_LONG];
      end
      if (en_ld)  en_q  <= en_d;
      if (ie_ld)  ie_q  <= ie_d;
      if (ovf_ld) ovf_q <= ovf_d;
      if (sel_ld) sel_q <= bus_wdata[SEL_W-1:0];
      if (usr_ld) usr_q <= bus_wdata[2:0] & 3'b101;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign acc_err   = err_q;
  assign irq       = |(ovf_q & ie_q);

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_priv,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        acc_err,
  input logic        ctrl_en_q,
  input logic [31:0] ovf_q,
  input logic [31:0] cnt0
);

  AST_ERR_NEEDS_UNPRIV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(bus_req && !bus_we && !bus_priv)); // R11

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (bus_rdata == 32'd0)); // R11

  AST_PRIV_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_priv) |=> !acc_err); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && bus_addr == 4'd5) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R8

  AST_WRAP_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == 32'd0 && $past(cnt0) == 32'hFFFF_FFFF && !$past(bus_req && bus_we)) |-> ovf_q[0]); // R8

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en_q && !(bus_req && bus_we)) |=> $stable(cnt0)); // R3

endmodule

bind perf_mon_unit pmu_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_priv (bus_priv),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .acc_err  (acc_err),
  .ctrl_en_q(ctrl_en_q),
  .ovf_q    (ovf_q),
  .cnt0     (evt_cnt[0])
);

// File: tb/tb_perf_mon_unit.sv
`timescale 1ns/1ps
module tb_perf_mon_unit;

  localparam int N     = 6;
  localparam int EVT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [EVT_W-1:0] events;
  logic             bus_req, bus_we, bus_priv;
  logic [3:0]       bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic             acc_err, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  perf_mon_unit #(.NUM_EVT(N), .EVT_W(EVT_W)) dut (
    .clk, .rst_n, .events, .bus_req, .bus_we, .bus_addr,
    .bus_wdata, .bus_priv, .bus_rdata, .acc_err, .irq
  );

  function automatic logic [31:0] exp_ctrl(input logic e, input logic lg);
    return (32'(N) << 11) | (32'(lg) << 6) | 32'(e);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic p, output logic [31:0] rdv, output logic errv);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rdv = bus_rdata; errv = acc_err;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] x; logic e;
    bus(1'b1, a, d, 1'b1, x, e);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    logic e;
    bus(1'b0, a, 32'd0, 1'b1, v, e);
  endtask

  task automatic load_evt(input int k, input logic [15:0] code, input logic [31:0] val);
    wr(4'd6, 32'(k));
    wr(4'd7, 32'(code));
    wr(4'd8, val);
  endtask

  task automatic read_evt(input int k, output logic [31:0] v);
    wr(4'd6, 32'(k));
    rd(4'd8, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, cnt;
    logic e;
    void'($urandom(32'h5EED_1234));
    events = '0; bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_priv = 1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(4'd0, v); check("R12 ctrl after reset", v, exp_ctrl(0, 0));
    rd(4'd1, v); check("R12 enables after reset", v, 32'd0);
    rd(4'd5, v); check("R12 ovf after reset", v, 32'd0);
    check("R12 irq after reset", 32'(irq), 32'd0);

    // R1 control fields
    wr(4'd0, 32'h0000_0047); rd(4'd0, v);
    check("R1 control readback", v, exp_ctrl(1, 1));
    wr(4'd0, 32'h0);

    // R2 enable set/clear
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); check("R2 set mask", v, 32'h8000_003F);
    wr(4'd2, 32'h8000_0001); rd(4'd2, v); check("R2 clear mask", v, 32'h0000_003E);
    wr(4'd1, 32'h0000_0001); rd(4'd1, v); check("R2 zeros keep", v, 32'h0000_003F);

    // R4 cycle-type event counter alongside cycle counter, cleared via R6
    load_evt(1, 16'h0011, 32'd0);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    repeat (10) @(negedge clk);
    wr(4'd0, 32'h0);
    read_evt(1, v); check("R4 cycle-code count", v, 32'd12);
    rd(4'd9, v);    check("R9 cycle counter count", v, 32'd12);

    // R11 access gating
    bus(1'b0, 4'd0, 0, 1'b0, v, e);
    check("R11 blocked data", v, 32'd0); check("R11 blocked err", 32'(e), 32'd1);
    @(negedge clk); check("R11 err one cycle", 32'(acc_err), 32'd0);
    wr(4'd11, 32'h4);
    bus(1'b0, 4'd9, 0, 1'b0, v, e);
    check("R11 cyc user read", v, 32'd12); check("R11 cyc user no err", 32'(e), 32'd0);
    bus(1'b0, 4'd1, 0, 1'b0, v, e);
    check("R11 cyc-only blocks mask", 32'(e), 32'd1);
    wr(4'd11, 32'h1);
    bus(1'b0, 4'd1, 0, 1'b0, v, e);
    check("R11 all user read", v, 32'h8000_003F);
    wr(4'd11, 32'h0);
    bus(1'b0, 4'd1, 0, 1'b1, v, e);
    check("R11 priv never blocked", 32'(e), 32'd0);

    // R6 clears
    wr(4'd0, 32'h4); read_evt(1, v); check("R6 event clear", v, 32'd0);
    wr(4'd0, 32'h2); rd(4'd9, v);    check("R6 cycle clear", v, 32'd0);

    // R5 software increment; R3 disabled gate
    wr(4'd2, 32'h8000_0000);
    load_evt(3, 16'h0000, 32'd10);
    load_evt(4, 16'h0009, 32'd20);
    wr(4'd12, 32'h8);
    read_evt(3, v); check("R3 swinc blocked when off", v, 32'd10);
    wr(4'd0, 32'h1);
    wr(4'd12, 32'h18);
    wr(4'd0, 32'h0);
    read_evt(3, v); check("R5 swinc advances", v, 32'd11);
    read_evt(4, v); check("R5 non-sw type unaffected", v, 32'd20);

    // R7 indirect, unimplemented select
    load_evt(0, 16'h0003, 32'h123);
    wr(4'd6, 32'd6); wr(4'd8, 32'h55); wr(4'd7, 32'h7);
    rd(4'd8, v); check("R7 unimpl count reads 0", v, 32'd0);
    rd(4'd7, v); check("R7 unimpl type reads 0", v, 32'd0);
    read_evt(0, v); check("R7 counter 0 untouched", v, 32'h123);
    rd(4'd7, v); check("R7 type readback", v, 32'h3);

    // R3 random event streams
    for (int r = 0; r < 8; r++) begin
      int k, c, exp_n;
      logic [31:0] start;
      k = $urandom_range(0, N-1);
      do c = $urandom_range(1, EVT_W-1); while (c == 17);
      start = $urandom() & 32'h7FFF_FFFF;
      load_evt(k, 16'(c), start);
      wr(4'd0, 32'h1);
      exp_n = 0;
      for (int j = 0; j < 24; j++) begin
        logic [31:0] rv;
        rv = $urandom();
        @(negedge clk); events = rv;
        exp_n += int'(rv[c]);
      end
      @(negedge clk); events = '0;
      wr(4'd0, 32'h0);
      read_evt(k, cnt);
      check("R3 random event count", cnt, start + 32'(exp_n));
    end

    // R8 / R10 event overflow and interrupt
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd3, 32'h4);
    load_evt(2, 16'h0005, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    @(negedge clk); events = 32'h20;
    @(negedge clk); events = '0;
    @(negedge clk); events = 32'h20;
    @(negedge clk); events = '0;
    wr(4'd0, 32'h0);
    read_evt(2, v); check("R8 wrapped to zero", v, 32'd0);
    rd(4'd5, v);    check("R8 status bit set", v, 32'h4);
    check("R10 irq raised", 32'(irq), 32'd1);
    repeat (3) @(negedge clk);
    rd(4'd5, v);    check("R8 status sticky", v, 32'h4);
    wr(4'd4, 32'h4);
    check("R10 irq masked by ie clear", 32'(irq), 32'd0);
    wr(4'd3, 32'h4);
    wr(4'd5, 32'h4);
    rd(4'd5, v);    check("R8 write-one clear", v, 32'd0);
    check("R10 irq dropped", 32'(irq), 32'd0);

    // R9 cycle overflow width
    wr(4'd1, 32'h8000_0000);
    wr(4'd9, 32'hFFFF_FFF0); wr(4'd10, 32'h0);
    wr(4'd0, 32'h41);
    repeat (40) @(negedge clk);
    wr(4'd0, 32'h40);
    rd(4'd5, v);  check("R9 long mode no 32-bit flag", v, 32'd0);
    rd(4'd10, v); check("R9 high half carries", v, 32'd1);
    rd(4'd9, v);  check("R9 low half value", v, 32'h1A);
    wr(4'd9, 32'hFFFF_FFF0); wr(4'd10, 32'h0);
    wr(4'd0, 32'h1);
    repeat (40) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd5, v);  check("R9 short mode flags bit 31", v, 32'h8000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule